// File: doc/BRIEF.md
# Bus-to-Device Four-Phase Handshake Controller

This clocked control block bridges a backplane bus master and a peripheral's data transceiver. A read strobe or a write strobe from the bus starts a transfer. The controller then exchanges a four-phase request/acknowledge handshake with the device. It opens the transceiver at the point in the sequence where the data must flow, and it acknowledges the bus once the device has answered. All inputs are expected to be synchronous to `clk` already.

Each output moves by at most one step per clock, and only after the input that enables that step has been sampled. Where the return-to-zero of the bus acknowledge and of the device request could happen in either order, the controller drops the bus acknowledge first and the device request one clock later.

A single internal phase bit is high during the active half of a cycle and low during the return half. Because of this bit, a read strobe that rises again before the device request has fallen is recognised as a new request and not as a read still in progress. A sticky flag reports inputs that arrive out of protocol order.

Top module: `busdev_hs_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `dev_req`, `xcvr_oe`, `bus_ack` and `proto_err` are 0 after that edge, and the controller is idle.
- R2: Read sequence:
  - `dev_req` rises on the 2nd edge after a rise of `bus_rd` is sampled.
  - `xcvr_oe` rises on the edge that samples `dev_ack` high.
  - `bus_ack` rises one edge later.
  - When `bus_rd` is sampled low, `xcvr_oe` falls on that edge.
  - `bus_ack` falls 2 edges after `xcvr_oe` falls.
  - `dev_req` falls one edge after `bus_ack` falls.
- R3: Write sequence:
  - `xcvr_oe` rises on the 2nd edge after `bus_wr` is sampled high.
  - `dev_req` rises one edge later.
  - `xcvr_oe` falls on the edge that samples `dev_ack` high.
  - `bus_ack` rises one edge later.
  - Once `bus_wr` is sampled low, `bus_ack` falls 2 edges later.
  - `dev_req` falls one edge after `bus_ack` falls.
- R4: `bus_ack` rises only after an edge that sampled `dev_ack` high.
- R5: `dev_req` rises only after an edge that sampled `dev_ack` low, so a new cycle waits for the previous device acknowledge to fall.
- R6: At most one of `dev_req`, `xcvr_oe` and `bus_ack` changes on any clock edge.
- R7: If `bus_rd` rises again after `bus_ack` has fallen but before `dev_req` has fallen, the controller finishes the return:
  - `dev_req` falls on the next edge.
  - `xcvr_oe` stays low.
  - The new read starts with `dev_req` rising 2 edges after `dev_ack` is sampled low.
- R8: While the controller waits for an input, all three outputs keep their values.
- R9: `proto_err` rises on the edge that samples any of the following:
  - `dev_ack` rising while `dev_req` is low.
  - `dev_ack` falling while `dev_req` is high.
  - A bus strobe falling while `bus_ack` is low.
  - Both strobes high at once.
- R10: Once set, `proto_err` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| dev_ack | input | 1 | Device acknowledge |
| dev_req | output | 1 | Request strobe to the device |
| xcvr_oe | output | 1 | Data transceiver enable |
| bus_ack | output | 1 | Acknowledge to the bus |
| proto_err | output | 1 | Sticky protocol-order violation flag |

## Verification
The hardest situation to reach is the re-raised read strobe during the return phase. In that state all outputs and inputs match the phase of an ongoing read that waits to open the transceiver, so only the phase bit tells the two apart. A bus model that waits politely for the whole handshake never gets there. The directed test therefore raises `bus_rd` on the exact cycle that `bus_ack` is seen falling, while `dev_ack` is still held high. It then checks that `dev_req` still falls, that the transceiver stays closed, and that the new request waits for the device acknowledge to drop. The table-driven part varies bus and device response delays so that every wait state is held for zero to three cycles.

// File: rtl/busdev_hs_pkg.sv
// Shared types for the bus-to-device handshake controller.
package busdev_hs_pkg;

    // Number of registered control bits: phase, request, enable, acknowledge.
    localparam int unsigned HS_STATE_W = 4;

    // Registered controller state. The phase bit separates the active half of
    // a cycle (1) from its return half (0).
    typedef struct packed {
        logic phase;
        logic req;
        logic oe;
        logic ack;
    } hs_state_t;

endpackage

// File: rtl/hs_next_state.sv
// Next-state logic of the handshake controller.
// Computes one output or phase step from the sampled strobes, the device
// acknowledge and the current state. Each branch is exclusive, so at most one
// bit changes per evaluation. Assumes inputs are synchronous to the clock.
module hs_next_state
    import busdev_hs_pkg::*;
(
    input  logic      rd_i,
    input  logic      wr_i,
    input  logic      dack_i,
    input  hs_state_t cur_i,
    output hs_state_t nxt_o
);

    logic c, r, e, a;
    assign c = cur_i.phase;
    assign r = cur_i.req;
    assign e = cur_i.oe;
    assign a = cur_i.ack;

    // Select the single transition enabled in the current state, if any.
    always_comb begin
        nxt_o = cur_i;
        if (!c && (rd_i || wr_i) && !r && !dack_i && !e && !a) begin
            nxt_o.phase = 1'b1;                       // cycle accepted
        end else if (c && !r && !dack_i && !a && ((rd_i && !e) || (wr_i && e))) begin
            nxt_o.req = 1'b1;                         // request device
        end else if (c && wr_i && !r && !e && !a) begin
            nxt_o.oe = 1'b1;                          // write: drive data first
        end else if (c && rd_i && r && dack_i && !e && !a) begin
            nxt_o.oe = 1'b1;                          // read: data valid
        end else if (c && rd_i && r && dack_i && e && !a) begin
            nxt_o.ack = 1'b1;                         // read: acknowledge bus
        end else if (c && wr_i && r && dack_i && e && !a) begin
            nxt_o.oe = 1'b0;                          // write: device latched data
        end else if (c && wr_i && r && dack_i && !e && !a) begin
            nxt_o.ack = 1'b1;                         // write: acknowledge bus
        end else if (c && !rd_i && !wr_i && e && a) begin
            nxt_o.oe = 1'b0;                          // read: strobe gone, close
        end else if (c && !rd_i && !wr_i && !e && a) begin
            nxt_o.phase = 1'b0;                       // enter return half
        end else if (!c && a) begin
            nxt_o.ack = 1'b0;                         // release bus first
        end else if (!c && r && !a && !e) begin
            nxt_o.req = 1'b0;                         // then release device
        end
    end

endmodule

// File: rtl/hs_violation_mon.sv
// Protocol-order monitor for the handshake controller.
// Keeps the previous input samples and raises a sticky flag when an input
// edge arrives in a state that forbids it. Assumes inputs are low in reset.
module hs_violation_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_i,
    input  logic wr_i,
    input  logic dack_i,
    input  logic req_i,
    input  logic ack_i,
    output logic err_o
);

    logic rd_q, wr_q, dack_q;
    logic bad;

    // Detect any input edge that breaks the handshake order.
    always_comb begin
        bad = 1'b0;
        if (dack_i && !dack_q && !req_i) bad = 1'b1;
        if (!dack_i && dack_q && req_i)  bad = 1'b1;
        if (!rd_i && rd_q && !ack_i)     bad = 1'b1;
        if (!wr_i && wr_q && !ack_i)     bad = 1'b1;
        if (rd_i && wr_i)                bad = 1'b1;
    end

    // Register previous inputs and accumulate the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= 1'b0;
            wr_q   <= 1'b0;
            dack_q <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            rd_q   <= rd_i;
            wr_q   <= wr_i;
            dack_q <= dack_i;
            err_o  <= err_o | bad;
        end
    end

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    a_r9_both_strobes_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && wr_i) |=> err_o);

endmodule

// File: rtl/busdev_hs_ctrl.sv
// Bus-to-device four-phase handshake controller (top).
// Holds the registered phase/request/enable/acknowledge state, advances it by
// at most one step per clock, and reports protocol-order violations.
// Assumes bus strobes and device acknowledge are already synchronized.
module busdev_hs_ctrl
    import busdev_hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_rd,
    input  logic bus_wr,
    input  logic dev_ack,
    output logic dev_req,
    output logic xcvr_oe,
    output logic bus_ack,
    output logic proto_err
);

    hs_state_t st_q, st_d;

    hs_next_state u_next (
        .rd_i   (bus_rd),
        .wr_i   (bus_wr),
        .dack_i (dev_ack),
        .cur_i  (st_q),
        .nxt_o  (st_d)
    );

    // State register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    hs_violation_mon u_mon (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_i   (bus_rd),
        .wr_i   (bus_wr),
        .dack_i (dev_ack),
        .req_i  (st_q.req),
        .ack_i  (st_q.ack),
        .err_o  (proto_err)
    );

    assign dev_req = st_q.req;
    assign xcvr_oe = st_q.oe;
    assign bus_ack = st_q.ack;

    a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({dev_req, xcvr_oe, bus_ack} ^ $past({dev_req, xcvr_oe, bus_ack})) <= 1);

    a_r4_ack_after_dev: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ack) |-> $past(dev_ack));

    a_r5_req_needs_dev_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_req) |-> !$past(dev_ack));

    a_r2_read_oe_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(xcvr_oe) && $past(bus_rd)) |-> ($past(dev_req) && $past(dev_ack)));

    a_r3_write_oe_before_req: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dev_req) && $past(bus_wr)) |-> $past(xcvr_oe));

endmodule

// File: tb/busdev_hs_ctrl_tb_top.sv
module busdev_hs_ctrl_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_rd = 1'b0, bus_wr = 1'b0, dev_ack = 1'b0;
    logic dev_req, xcvr_oe, bus_ack, proto_err;
    int   vecs = 0;
    int   miss = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    busdev_hs_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .dev_ack(dev_ack), .dev_req(dev_req), .xcvr_oe(xcvr_oe),
        .bus_ack(bus_ack), .proto_err(proto_err)
    );

    // Table entries: {write, master delay[1:0], device delay[1:0]}.
    localparam int NV = 10;
    localparam logic [4:0] VEC [NV] = '{
        5'b0_00_00, 5'b1_00_00, 5'b0_01_10, 5'b1_10_01, 5'b0_11_11,
        5'b1_11_00, 5'b0_00_11, 5'b1_01_11, 5'b0_10_01, 5'b1_00_10
    };

    function automatic logic [2:0] outs();
        return {dev_req, xcvr_oe, bus_ack};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vecs++;
        if (!ok) begin
            miss++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Wait for output idx (2 req, 1 oe, 0 ack) to reach val; check latency and
    // that nothing else moved.
    task automatic wait_out(input int idx, input logic val, input int exp_lat, input string tag);
        logic [2:0] snap;
        logic [2:0] cur;
        int lat;
        snap = outs();
        cur  = snap;
        lat  = 0;
        while (cur[idx] !== val && lat < 40) begin
            @(negedge clk);
            lat++;
            cur = outs();
        end
        chk(lat == exp_lat, tag, lat, exp_lat);
        chk((cur ^ snap) == (3'b001 << idx), {tag, " single step (R6)"},
            int'(cur ^ snap), int'(3'b001 << idx));
    endtask

    task automatic hold(input int n, input string tag);
        logic [2:0] snap;
        snap = outs();
        if (n > 0) begin
            repeat (n) @(negedge clk);
            chk(outs() == snap, tag, int'(outs()), int'(snap));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; dev_ack = 1'b0;
        repeat (2) @(negedge clk);
        chk({outs(), proto_err} == 4'b0, "R1 reset state", int'({outs(), proto_err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic read_cycle(input int dm, input int dd);
        bus_rd = 1'b1;
        wait_out(2, 1'b1, 2, "R2 req rise");
        hold(dd, "R8 hold awaiting device");
        dev_ack = 1'b1;
        wait_out(1, 1'b1, 1, "R2 oe rise");
        wait_out(0, 1'b1, 1, "R4 bus ack after device ack");
        hold(dm, "R8 hold awaiting master");
        bus_rd = 1'b0;
        wait_out(1, 1'b0, 1, "R2 oe fall");
        wait_out(0, 1'b0, 2, "R2 bus ack fall");
        wait_out(2, 1'b0, 1, "R2 req fall");
        hold(dd, "R8 hold awaiting device release");
        dev_ack = 1'b0;
        chk(proto_err == 1'b0, "R9 no error on legal read", proto_err, 0);
    endtask

    task automatic write_cycle(input int dm, input int dd);
        bus_wr = 1'b1;
        wait_out(1, 1'b1, 2, "R3 oe rise");
        wait_out(2, 1'b1, 1, "R3 req rise");
        hold(dd, "R8 hold awaiting device");
        dev_ack = 1'b1;
        wait_out(1, 1'b0, 1, "R3 oe fall");
        wait_out(0, 1'b1, 1, "R3 bus ack rise");
        hold(dm, "R8 hold awaiting master");
        bus_wr = 1'b0;
        wait_out(0, 1'b0, 2, "R3 bus ack fall");
        wait_out(2, 1'b0, 1, "R3 req fall");
        hold(dd, "R8 hold awaiting device release");
        dev_ack = 1'b0;
        chk(proto_err == 1'b0, "R9 no error on legal write", proto_err, 0);
    endtask

    initial begin
        do_reset();

        // Back-to-back table-driven cycles.
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][4]) write_cycle(int'(VEC[i][3:2]), int'(VEC[i][1:0]));
            else           read_cycle(int'(VEC[i][3:2]), int'(VEC[i][1:0]));
        end

        // R7: read strobe re-raised during the return half.
        do_reset();
        bus_rd = 1'b1;
        wait_out(2, 1'b1, 2, "R7 setup req rise");
        dev_ack = 1'b1;
        wait_out(1, 1'b1, 1, "R7 setup oe rise");
        wait_out(0, 1'b1, 1, "R7 setup bus ack rise");
        bus_rd = 1'b0;
        wait_out(1, 1'b0, 1, "R7 setup oe fall");
        wait_out(0, 1'b0, 2, "R7 setup bus ack fall");
        bus_rd = 1'b1;
        wait_out(2, 1'b0, 1, "R7 req falls despite new strobe");
        hold(3, "R5 no request while device ack high");
        chk(proto_err == 1'b0, "R7 re-raise is legal", proto_err, 0);
        dev_ack = 1'b0;
        wait_out(2, 1'b1, 2, "R7 new request after device release");
        dev_ack = 1'b1;
        wait_out(1, 1'b1, 1, "R7 new read oe rise");
        wait_out(0, 1'b1, 1, "R7 new read bus ack");
        bus_rd = 1'b0;
        wait_out(1, 1'b0, 1, "R7 new read oe fall");
        wait_out(0, 1'b0, 2, "R7 new read bus ack fall");
        wait_out(2, 1'b0, 1, "R7 new read req fall");
        dev_ack = 1'b0;

        // R9/R10: device ack rising with no request.
        do_reset();
        dev_ack = 1'b1;
        @(negedge clk);
        chk(proto_err == 1'b1, "R9 ack without request", proto_err, 1);
        dev_ack = 1'b0;
        repeat (3) @(negedge clk);
        chk(proto_err == 1'b1, "R10 flag sticky", proto_err, 1);
        chk(outs() == 3'b000, "R9 outputs idle after stray ack", int'(outs()), 0);

        // R9: read strobe dropped before bus ack.
        do_reset();
        chk(proto_err == 1'b0, "R1 reset clears flag", proto_err, 0);
        bus_rd = 1'b1;
        wait_out(2, 1'b1, 2, "R9 setup req rise");
        bus_rd = 1'b0;
        @(negedge clk);
        chk(proto_err == 1'b1, "R9 early strobe fall", proto_err, 1);

        // R9: both strobes together.
        do_reset();
        bus_rd = 1'b1; bus_wr = 1'b1;
        @(negedge clk);
        chk(proto_err == 1'b1, "R9 both strobes", proto_err, 1);

        // R9: device ack dropped while request high.
        do_reset();
        bus_rd = 1'b1;
        wait_out(2, 1'b1, 2, "R9 setup2 req rise");
        dev_ack = 1'b1;
        wait_out(1, 1'b1, 1, "R9 setup2 oe rise");
        dev_ack = 1'b0;
        @(negedge clk);
        chk(proto_err == 1'b1, "R9 early device release", proto_err, 1);

        do_reset();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miss++;
            vecs++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
            $finish;
        end
    end

endmodule